// File: doc/BRIEF.md
# Zero-crossing stereo mute controller

This block decides, cycle by cycle, whether each of two audio channels (left and right) is muted. A register block supplies a general-mute request bit, a mode bit that selects direct or zero-crossing switching, and a strobe that pulses whenever the switch register holding those bits is written. An active-low hardware mute pin, one signed sample stream per channel (with a shared valid strobe), a programmable zero-window threshold and a periodic timing tick complete the inputs. The block drives one mute enable and one pending flag per channel.

In direct mode a channel's mute switch follows the request at once. In zero-crossing mode a change, whether muting or unmuting, is held back until that channel's own signal crosses zero, so the switch never cuts a waveform at a large amplitude. A crossing is either a valid sample whose magnitude lies inside the threshold window, or a sign flip between two consecutive valid samples. A tick-counted timeout, restarted by every switch-register write, forces any held-back change when no crossing arrives. The hardware pin mutes everything immediately while low and keeps the outputs muted for a short tick-counted release time after it returns high; it is never stored.

Each channel is a four-state machine: `CH_MUTED` (switch closed to mute, settled), `CH_OPEN` (signal passes, settled), `CH_ARM_MUTE` (passing, mute requested, waiting for a crossing) and `CH_ARM_OPEN` (muted, unmute requested, waiting). Transitions: settled state to its opposite settled state in direct mode (`direct`); settled state to its arm state in zero-crossing mode (`arm`); arm state to the opposite settled state on a crossing, an expiry, or a switch to direct mode (`fire`); arm state back to its own settled state when the request returns to the current switch position (`withdraw`).

Top module: `zc_mute_ctrl`

## Requirements
- R1: After reset both mute outputs are 1 and both pending flags are 0 while the request bit is 1.
- R2: With the mode bit 0, each channel's switch state equals the request bit one clock edge after it is sampled, and the pending flags are 0.
- R3: With the mode bit 1, a change of the request bit (mute or unmute) raises that channel's pending flag and leaves its mute output unchanged until a crossing or an expiry on that channel; it is then applied two clock edges after the crossing sample is taken, and the pending flag clears.
- R4: A valid sample is a crossing when its magnitude (absolute value of the two's-complement sample) is less than or equal to the threshold input; magnitude one above the threshold is not a crossing by this rule.
- R5: A valid sample whose sign bit differs from that of the previous valid sample on the same channel is a crossing, even when both lie outside the window.
- R6: The two channels have separate detectors and state machines; a crossing on one channel never changes the other channel's output.
- R7: Every switch-register write restarts a timeout of TIMEOUT_TICKS tick pulses; on expiry any pending channel takes the requested state, and fewer ticks since the latest write leave it pending.
- R8: While the hardware mute pin is 0, both mute outputs are 1 in the same cycle, whatever the register state.
- R9: After the pin returns to 1, both outputs stay muted until RELEASE_TICKS tick pulses have occurred and then show the register-controlled state; the pin state is not stored.
- R10: If the request bit returns to the current switch position while a channel is pending, the pending flag clears and the mute output never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timing tick pulse |
| req_mute_i | input | 1 | General-mute request bit from the register block |
| zc_mode_i | input | 1 | 1: defer changes to zero crossings, 0: direct |
| sw_wr_i | input | 1 | Pulse on every switch-register write |
| hw_mute_n_i | input | 1 | Hardware mute pin, active low |
| zc_thresh_i | input | SAMPLE_W | Unsigned zero-window threshold on sample magnitude |
| smp_vld_i | input | 1 | Sample valid strobe for both channels |
| smp_l_i | input | SAMPLE_W | Left sample, two's complement |
| smp_r_i | input | SAMPLE_W | Right sample, two's complement |
| mute_l_o | output | 1 | Left mute enable (1 = muted) |
| mute_r_o | output | 1 | Right mute enable (1 = muted) |
| pend_l_o | output | 1 | Left change pending |
| pend_r_o | output | 1 | Right change pending |

## Verification
The assertions assume the request and mode bits change only together with a switch-register write pulse, that tick pulses and write pulses never coincide, and that the hardware release time is at least one tick. The stimulus drives every register-bit change through a single write task, issues ticks from a separate task between writes, and feeds two identical out-of-window samples before each arming so the sign history is known. The threshold sweep keeps the other channel's sample far from zero with an unchanged sign, so its state must stay pending throughout.

// File: rtl/zcm_pkg.sv
package zcm_pkg;

    typedef enum logic [1:0] {
        CH_MUTED    = 2'd0,
        CH_OPEN     = 2'd1,
        CH_ARM_MUTE = 2'd2,
        CH_ARM_OPEN = 2'd3
    } ch_state_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/zcm_zero_det.sv
module zcm_zero_det #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic [SAMPLE_W-1:0] thresh_i,
    output logic                hit_o
);

    logic [SAMPLE_W-1:0] mag;
    logic                in_win;
    logic                prev_sgn;
    logic                prev_vld;
    logic                flip;
    logic                hit_q;

    always_comb begin
        mag    = smp_i[SAMPLE_W-1] ? (~smp_i + 1'b1) : smp_i;
        in_win = (mag <= thresh_i);
        flip   = prev_vld && (prev_sgn != smp_i[SAMPLE_W-1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sgn <= 1'b0;
            prev_vld <= 1'b0;
            hit_q    <= 1'b0;
        end else begin
            hit_q <= vld_i && (in_win || flip);
            if (vld_i) begin
                prev_sgn <= smp_i[SAMPLE_W-1];
                prev_vld <= 1'b1;
            end
        end
    end

    assign hit_o = hit_q;

    // R4: a valid sample at magnitude zero always yields a crossing pulse
    a_r4_zero_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && (smp_i == '0)) |=> hit_o);

    // R5: a sign flip between consecutive valid samples yields a crossing pulse
    a_r5_flip_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && prev_vld && (smp_i[SAMPLE_W-1] != prev_sgn)) |=> hit_o);

    // R4: no valid sample, no crossing
    a_r4_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !hit_o);

endmodule

// File: rtl/zcm_timeout.sv
module zcm_timeout #(
    parameter int TIMEOUT_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    output logic expire_o
);

    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt;
    logic          run;
    logic          exp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            run   <= 1'b0;
            exp_q <= 1'b0;
        end else if (restart_i) begin
            cnt   <= '0;
            run   <= 1'b1;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (run && tick_i) begin
                if (cnt == LAST) begin
                    run   <= 1'b0;
                    exp_q <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign expire_o = exp_q;

    // R7: expiry is a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);

    // R7: a write cancels any expiry in the following cycle
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !expire_o);

endmodule

// File: rtl/zcm_hw_release.sv
module zcm_hw_release #(
    parameter int RELEASE_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_n_i,
    output logic force_o
);

    localparam int CW = $clog2(RELEASE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(RELEASE_TICKS - 1);

    logic [CW-1:0] cnt;
    logic          hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            hold <= 1'b0;
        end else if (!pin_n_i) begin
            cnt  <= '0;
            hold <= 1'b1;
        end else if (hold && tick_i) begin
            if (cnt == LAST) begin
                hold <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign force_o = !pin_n_i || hold;

    // R9: a rising pin edge never drops the force in the same cycle
    a_r9_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_n_i) |-> force_o);

    // R9: without a tick the force cannot end
    a_r9_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (force_o && !tick_i) |=> force_o);

endmodule

// File: rtl/zcm_chan_fsm.sv
module zcm_chan_fsm
    import zcm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_mute_i,
    input  logic zc_mode_i,
    input  logic zc_hit_i,
    input  logic tmo_i,
    output logic sw_mute_o,
    output logic pend_o
);

    ch_state_e state, state_nx;
    logic      fire;

    always_comb begin
        fire     = !zc_mode_i || zc_hit_i || tmo_i;
        state_nx = state;
        unique case (state)
            CH_MUTED: begin
                if (!req_mute_i)
                    state_nx = zc_mode_i ? CH_ARM_OPEN : CH_OPEN;
            end
            CH_OPEN: begin
                if (req_mute_i)
                    state_nx = zc_mode_i ? CH_ARM_MUTE : CH_MUTED;
            end
            CH_ARM_MUTE: begin
                if (!req_mute_i)
                    state_nx = CH_OPEN;
                else if (fire)
                    state_nx = CH_MUTED;
            end
            CH_ARM_OPEN: begin
                if (req_mute_i)
                    state_nx = CH_MUTED;
                else if (fire)
                    state_nx = CH_OPEN;
            end
            default: state_nx = CH_MUTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= CH_MUTED;
        else
            state <= state_nx;
    end

    always_comb begin
        sw_mute_o = (state == CH_MUTED) || (state == CH_ARM_OPEN);
        pend_o    = (state == CH_ARM_MUTE) || (state == CH_ARM_OPEN);
    end

    // R2: in direct mode the switch takes the request at the next edge
    a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n)
        !zc_mode_i |=> (sw_mute_o == $past(req_mute_i)));

    // R3: in crossing mode, with no crossing and no expiry, the switch holds
    a_r3_defer: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_mode_i && !zc_hit_i && !tmo_i) |=> (sw_mute_o == $past(sw_mute_o)));

    // R10: a pending channel whose request matches its switch stops pending
    a_r10_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && (req_mute_i == sw_mute_o)) |=> (!pend_o && (sw_mute_o == $past(sw_mute_o))));

endmodule

// File: rtl/zc_mute_ctrl.sv
module zc_mute_ctrl
    import zcm_pkg::*;
#(
    parameter int SAMPLE_W      = 16,
    parameter int TIMEOUT_TICKS = 200,
    parameter int RELEASE_TICKS = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                req_mute_i,
    input  logic                zc_mode_i,
    input  logic                sw_wr_i,
    input  logic                hw_mute_n_i,
    input  logic [SAMPLE_W-1:0] zc_thresh_i,
    input  logic                smp_vld_i,
    input  logic [SAMPLE_W-1:0] smp_l_i,
    input  logic [SAMPLE_W-1:0] smp_r_i,
    output logic                mute_l_o,
    output logic                mute_r_o,
    output logic                pend_l_o,
    output logic                pend_r_o
);

    logic [SAMPLE_W-1:0] smp    [NUM_CH];
    logic [NUM_CH-1:0]   hit;
    logic [NUM_CH-1:0]   sw_mute;
    logic [NUM_CH-1:0]   pend;
    logic                tmo;
    logic                hw_force;

    assign smp[0] = smp_l_i;
    assign smp[1] = smp_r_i;

    zcm_timeout #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .restart_i (sw_wr_i),
        .expire_o  (tmo)
    );

    zcm_hw_release #(
        .RELEASE_TICKS (RELEASE_TICKS)
    ) u_hw (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .pin_n_i (hw_mute_n_i),
        .force_o (hw_force)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        zcm_zero_det #(
            .SAMPLE_W (SAMPLE_W)
        ) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .vld_i    (smp_vld_i),
            .smp_i    (smp[c]),
            .thresh_i (zc_thresh_i),
            .hit_o    (hit[c])
        );

        zcm_chan_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_mute_i (req_mute_i),
            .zc_mode_i  (zc_mode_i),
            .zc_hit_i   (hit[c]),
            .tmo_i      (tmo),
            .sw_mute_o  (sw_mute[c]),
            .pend_o     (pend[c])
        );
    end

    always_comb begin
        mute_l_o = sw_mute[0] || hw_force;
        mute_r_o = sw_mute[1] || hw_force;
        pend_l_o = pend[0];
        pend_r_o = pend[1];
    end

    // R8: pin low mutes both outputs in the same cycle
    a_r8_pin_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_mute_n_i |-> (mute_l_o && mute_r_o));

    // R6: a crossing on the left alone leaves the right switch untouched
    a_r6_independent: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_mode_i && hit[0] && !hit[1] && !tmo && pend[1] && (req_mute_i != sw_mute[1]))
            |=> (sw_mute[1] == $past(sw_mute[1])));

endmodule

// File: tb/sim_zc_mute_ctrl.sv
module sim_zc_mute_ctrl;

    localparam int W   = 16;
    localparam int TO  = 8;
    localparam int REL = 3;
    localparam int THR = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tick_i, req_mute_i, zc_mode_i, sw_wr_i, hw_mute_n_i, smp_vld_i;
    logic [W-1:0] zc_thresh_i, smp_l_i, smp_r_i;
    logic         mute_l_o, mute_r_o, pend_l_o, pend_r_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    zc_mute_ctrl #(
        .SAMPLE_W      (W),
        .TIMEOUT_TICKS (TO),
        .RELEASE_TICKS (REL)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .req_mute_i  (req_mute_i),
        .zc_mode_i   (zc_mode_i),
        .sw_wr_i     (sw_wr_i),
        .hw_mute_n_i (hw_mute_n_i),
        .zc_thresh_i (zc_thresh_i),
        .smp_vld_i   (smp_vld_i),
        .smp_l_i     (smp_l_i),
        .smp_r_i     (smp_r_i),
        .mute_l_o    (mute_l_o),
        .mute_r_o    (mute_r_o),
        .pend_l_o    (pend_l_o),
        .pend_r_o    (pend_r_o)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {mute_l,mute_r,pend_l,pend_r} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {mute_l_o, mute_r_o, pend_l_o, pend_r_o};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_sw(input logic gm, input logic zm);
        req_mute_i = gm;
        zc_mode_i  = zm;
        sw_wr_i    = 1'b1;
        @(negedge clk);
        sw_wr_i    = 1'b0;
    endtask

    task automatic put_smp(input int l, input int r);
        smp_l_i   = W'(l);
        smp_r_i   = W'(r);
        smp_vld_i = 1'b1;
        @(negedge clk);
        smp_vld_i = 1'b0;
    endtask

    task automatic pulse_tick(input int n);
        repeat (n) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        rst_n = 1'b0;
        tick_i = 1'b0; req_mute_i = 1'b1; zc_mode_i = 1'b0; sw_wr_i = 1'b0;
        hw_mute_n_i = 1'b1; smp_vld_i = 1'b0;
        zc_thresh_i = W'(THR); smp_l_i = '0; smp_r_i = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 reset state", outs(), 4'b1100);

        // R2: direct mode
        write_sw(1'b0, 1'b0);
        chk("R2 direct unmute", outs(), 4'b0000);
        write_sw(1'b1, 1'b0);
        chk("R2 direct mute", outs(), 4'b1100);
        write_sw(1'b0, 1'b0);
        chk("R2 direct unmute again", outs(), 4'b0000);

        // R4 sweep of the window on the left; R6 right stays pending
        for (int v = -2 * THR - 5; v <= 2 * THR + 5; v++) begin
            int  big;
            logic hit_exp;
            big = (v < 0) ? -1000 : 1000;
            write_sw(1'b0, 1'b0);
            write_sw(1'b0, 1'b1);
            put_smp(big, 1000);
            put_smp(big, 1000);
            cyc(2);
            write_sw(1'b1, 1'b1);
            cyc(1);
            chk("R3 armed mute holds", outs(), 4'b0011);
            put_smp(v, 1000);
            cyc(1);
            hit_exp = ((v < 0) ? -v : v) <= THR;
            chk($sformatf("R4 window v=%0d", v), outs(), {hit_exp, 1'b0, !hit_exp, 1'b1});
            chk("R6 right unaffected", {mute_r_o, pend_r_o, 2'b00}, 4'b0100);
        end
        write_sw(1'b0, 1'b0);
        chk("R2 back to open", outs(), 4'b0000);

        // R3 deferred unmute, R5 sign flip, R6 independence
        write_sw(1'b1, 1'b0);
        put_smp(1000, 1000);
        put_smp(1000, 1000);
        cyc(2);
        write_sw(1'b0, 1'b1);
        cyc(2);
        chk("R3 deferred unmute pending", outs(), 4'b1111);
        put_smp(-1000, 1000);
        cyc(1);
        chk("R5 sign flip opens left only", outs(), 4'b0101);
        put_smp(-1000, 5);
        cyc(1);
        chk("R4 right in window opens", outs(), 4'b0000);
        put_smp(1000, -1000);
        cyc(1);
        chk("R3 settled, crossings ignored", outs(), 4'b0000);

        // R10 withdraw
        put_smp(1000, 1000);
        put_smp(1000, 1000);
        cyc(1);
        write_sw(1'b1, 1'b1);
        chk("R10 request pending", outs(), 4'b0011);
        write_sw(1'b0, 1'b1);
        chk("R10 withdrawn", outs(), 4'b0000);
        put_smp(0, 0);
        cyc(1);
        chk("R10 no change after crossing", outs(), 4'b0000);

        // R7 timeout with restart
        put_smp(1000, 1000);
        put_smp(1000, 1000);
        cyc(1);
        write_sw(1'b1, 1'b1);
        pulse_tick(TO - 3);
        write_sw(1'b1, 1'b1);
        pulse_tick(TO - 1);
        chk("R7 not yet expired after restart", outs(), 4'b0011);
        pulse_tick(1);
        cyc(1);
        chk("R7 expiry forces mute", outs(), 4'b1100);

        // R8 / R9 hardware mute
        write_sw(1'b0, 1'b0);
        chk("R2 open before pin", outs(), 4'b0000);
        hw_mute_n_i = 1'b0;
        #1;
        chk("R8 pin mutes at once", outs(), 4'b1100);
        cyc(1);
        write_sw(1'b0, 1'b0);
        chk("R8 overrides register", outs(), 4'b1100);
        pulse_tick(2);
        chk("R8 ticks while low keep mute", outs(), 4'b1100);
        hw_mute_n_i = 1'b1;
        cyc(1);
        chk("R9 held after release", outs(), 4'b1100);
        pulse_tick(REL - 1);
        chk("R9 still held one tick short", outs(), 4'b1100);
        pulse_tick(1);
        chk("R9 register state returns", outs(), 4'b0000);
        write_sw(1'b1, 1'b0);
        chk("R9 pin not stored, register mute", outs(), 4'b1100);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule